// File: doc/BRIEF.md
# Configurable System Memory Map Decoder

This block sits on the 16-bit address bus of a small CPU system and works out, within the same cycle, which resource an access belongs to. The sources are main RAM, three ROM windows, three 32-byte peripheral windows, a boot/vector window, and a write-only window into the map-control register. It also produces the local address each resource should see. The decoder holds no state. The map-type, 64K-size and page bits come in as inputs from a control register held elsewhere.

The map depends on three inputs. With the all-RAM map and the 64K size both set, reads below 0xFF00 go to RAM, while the ROM windows still take the writes and also write through to RAM. In 64K mode with the ROM/RAM map, the page bit moves the low 32K of RAM accesses into the upper half of RAM. Reads and writes are decoded differently. The top 32 bytes of the space always map to a ROM window.

Top module: `msmd_top`

## Requirements
- R1: While `valid_i` is low, `sel_o`, `ram_we_thru_o` and `ctl_we_o` are all zero.
- R2: While `valid_i` is high, exactly one bit of `sel_o` is set. The bits are: bit0 RAM, bit1 ROM0, bit2 ROM1, bit3 ROM2, bit4 IO0, bit5 IO1, bit6 IO2, bit7 boot.
- R3: A write selects RAM only below 0x8000. A read selects RAM below 0xFF00 when both `mem_64k_i` and `map_all_ram_i` are 1, and below 0x8000 otherwise.
- R4: When RAM is selected below 0x8000 with `mem_64k_i`=1, `map_all_ram_i`=0 and `page_hi_i`=1, `ram_addr_o` is the bus address with bit 15 set. In every other RAM case `ram_addr_o` equals the bus address.
- R5: Addresses in 0x8000–0xBFFF or 0xFFE0–0xFFFF that are not RAM select ROM0 when address bit 13 is 0 and ROM1 when it is 1. `rom_addr_o` is then the low 13 address bits.
- R6: Addresses in 0xC000–0xFEFF that are not RAM select ROM2, with `rom_addr_o` equal to the low 14 address bits.
- R7: 0xFF00–0xFF5F selects IO0, IO1 or IO2 according to address bits 6:5 (values 0, 1, 2). `io_addr_o` is the low 5 bits.
- R8: 0xFF60–0xFFDF selects the boot window, with `boot_addr_o` equal to the address minus 0xFF60.
- R9: `ctl_we_o` is high only for a valid write in 0xFFC0–0xFFDF, with `ctl_ofs_o` equal to the low 5 address bits. Reads never raise it.
- R10: `ram_we_thru_o` is high only for a valid write in 0x8000–0xFEFF with `mem_64k_i`=1 and `map_all_ram_i`=1. It comes alongside the ROM select, with `ram_addr_o` equal to the bus address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock used only by the embedded checks |
| rst_ni | input | 1 | Active-low asynchronous reset for the checks |
| valid_i | input | 1 | Bus access in progress |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Bus address |
| map_all_ram_i | input | 1 | Map type: 1 = all RAM, 0 = ROM/RAM |
| mem_64k_i | input | 1 | Memory size is 64K |
| page_hi_i | input | 1 | Low-RAM page select |
| sel_o | output | 8 | One-hot primary region select |
| ram_we_thru_o | output | 1 | Extra RAM write enable for ROM-window writes |
| ram_addr_o | output | 16 | RAM local address |
| rom_addr_o | output | 14 | ROM local address |
| io_addr_o | output | 5 | Peripheral register offset |
| boot_addr_o | output | 7 | Boot window offset |
| ctl_we_o | output | 1 | Control-register write strobe |
| ctl_ofs_o | output | 5 | Control-register offset |

## Verification
The hardest case to reach is where map type, size and direction interact. A read and a write to the same ROM-window address must decode differently under the all-RAM map, and the page remap must apply only to low addresses in the ROM/RAM map. The stimulus therefore runs every combination of the three map bits with both directions. Each combination covers every byte of the top page and both ends of each 256-byte block below it. That lands on 0x7FFF/0x8000, 0xBFFF/0xC000, 0xFEFF/0xFF00, 0xFFDF/0xFFE0 and every peripheral and control offset.

// File: rtl/msmd_pkg.sv
package msmd_pkg;
  localparam int ADDR_W  = 16;
  localparam int ROM_W   = 14;
  localparam int ROMS_W  = 13;
  localparam int IO_W    = 5;
  localparam int BOOT_W  = 7;
  localparam int NUM_REG = 8;

  localparam logic [ADDR_W-1:0] RAM_SPLIT = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] ROM2_BASE = {2'b11, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] IO_BASE   = {{(ADDR_W-8){1'b1}}, 8'h00};
  localparam logic [ADDR_W-1:0] BOOT_BASE = {{(ADDR_W-8){1'b1}}, 8'h60};
  localparam logic [ADDR_W-1:0] CTL_BASE  = {{(ADDR_W-8){1'b1}}, 8'hC0};
  localparam logic [ADDR_W-1:0] VEC_BASE  = {{(ADDR_W-8){1'b1}}, 8'hE0};

  typedef enum logic [2:0] {
    REG_RAM  = 3'd0,
    REG_ROM0 = 3'd1,
    REG_ROM1 = 3'd2,
    REG_ROM2 = 3'd3,
    REG_IO0  = 3'd4,
    REG_IO1  = 3'd5,
    REG_IO2  = 3'd6,
    REG_BOOT = 3'd7
  } region_e;
endpackage

// File: rtl/msmd_ram_window.sv
module msmd_ram_window
  import msmd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic              map_all_ram_i,
  input  logic              mem_64k_i,
  input  logic              page_hi_i,
  output logic              hit_o,
  output logic              thru_o,
  output logic [ADDR_W-1:0] ram_addr_o
);
  logic all_ram;
  logic low_half;
  logic [ADDR_W-1:0] read_top;

  assign all_ram  = mem_64k_i & map_all_ram_i;
  assign low_half = addr_i < RAM_SPLIT;
  assign read_top = all_ram ? IO_BASE : RAM_SPLIT;

  // reads and writes see different RAM upper bounds
  assign hit_o  = write_i ? low_half : (addr_i < read_top);
  assign thru_o = write_i & all_ram & ~low_half & (addr_i < IO_BASE);

  always_comb begin
    ram_addr_o = addr_i;
    if (mem_64k_i && !map_all_ram_i && page_hi_i && low_half)
      ram_addr_o[ADDR_W-1] = 1'b1;
  end
endmodule

// File: rtl/msmd_upper_decode.sv
module msmd_upper_decode
  import msmd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [ROM_W-1:0]  rom_addr_o,
  output logic [IO_W-1:0]   io_addr_o,
  output logic [BOOT_W-1:0] boot_addr_o
);
  logic vec_alias;
  assign vec_alias = addr_i >= VEC_BASE;

  always_comb begin
    if (addr_i < ROM2_BASE || vec_alias) begin
      region_o   = addr_i[ROMS_W] ? REG_ROM1 : REG_ROM0;
      rom_addr_o = {1'b0, addr_i[ROMS_W-1:0]};
    end else if (addr_i < IO_BASE) begin
      region_o   = REG_ROM2;
      rom_addr_o = addr_i[ROM_W-1:0];
    end else if (addr_i < BOOT_BASE) begin
      rom_addr_o = addr_i[ROM_W-1:0];
      case (addr_i[IO_W+1:IO_W])
        2'd0:    region_o = REG_IO0;
        2'd1:    region_o = REG_IO1;
        default: region_o = REG_IO2;
      endcase
    end else begin
      region_o   = REG_BOOT;
      rom_addr_o = addr_i[ROM_W-1:0];
    end
  end

  assign io_addr_o   = addr_i[IO_W-1:0];
  // low 7 bits minus 0x60 wrap to the 0..0x7F window offset
  assign boot_addr_o = addr_i[BOOT_W-1:0] - BOOT_BASE[BOOT_W-1:0];
endmodule

// File: rtl/msmd_ctl_strobe.sv
module msmd_ctl_strobe
  import msmd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              valid_i,
  input  logic              write_i,
  output logic              we_o,
  output logic [IO_W-1:0]   ofs_o
);
  assign we_o  = valid_i & write_i & (addr_i >= CTL_BASE) & (addr_i < VEC_BASE);
  assign ofs_o = addr_i[IO_W-1:0];
endmodule

// File: rtl/msmd_top.sv
module msmd_top
  import msmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              map_all_ram_i,
  input  logic              mem_64k_i,
  input  logic              page_hi_i,
  output logic [NUM_REG-1:0] sel_o,
  output logic              ram_we_thru_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [ROM_W-1:0]  rom_addr_o,
  output logic [IO_W-1:0]   io_addr_o,
  output logic [BOOT_W-1:0] boot_addr_o,
  output logic              ctl_we_o,
  output logic [IO_W-1:0]   ctl_ofs_o
);
  logic    ram_hit;
  logic    ram_thru;
  region_e upper_region;
  region_e region;

  msmd_ram_window u_ram (
    .addr_i        (addr_i),
    .write_i       (write_i),
    .map_all_ram_i (map_all_ram_i),
    .mem_64k_i     (mem_64k_i),
    .page_hi_i     (page_hi_i),
    .hit_o         (ram_hit),
    .thru_o        (ram_thru),
    .ram_addr_o    (ram_addr_o)
  );

  msmd_upper_decode u_upper (
    .addr_i      (addr_i),
    .region_o    (upper_region),
    .rom_addr_o  (rom_addr_o),
    .io_addr_o   (io_addr_o),
    .boot_addr_o (boot_addr_o)
  );

  msmd_ctl_strobe u_ctl (
    .addr_i  (addr_i),
    .valid_i (valid_i),
    .write_i (write_i),
    .we_o    (ctl_we_o),
    .ofs_o   (ctl_ofs_o)
  );

  assign region        = ram_hit ? REG_RAM : upper_region;
  assign ram_we_thru_o = valid_i & ram_thru;

  for (genvar g = 0; g < NUM_REG; g++) begin : g_sel
    assign sel_o[g] = valid_i & (region == region_e'(g));
  end

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (sel_o == '0) && !ram_we_thru_o && !ctl_we_o);

  assert_one_region_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $onehot(sel_o));

  assert_read_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o[0] && !write_i) |-> (addr_i < IO_BASE));

  assert_write_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o[0] && write_i) |-> (addr_i < RAM_SPLIT));

  assert_high_ram_unmoved_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o[0] && addr_i[ADDR_W-1]) |-> (ram_addr_o == addr_i));

  assert_ctl_in_boot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_o |-> (write_i && sel_o[7]));

  assert_thru_on_rom_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_thru_o |-> (write_i && (sel_o[1] || sel_o[2] || sel_o[3])
                       && ram_addr_o == addr_i));
endmodule

// File: tb/sim_msmd_top.sv
module sim_msmd_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] addr = '0;
  logic        ty = 1'b0;
  logic        m64 = 1'b0;
  logic        p1 = 1'b0;
  logic [7:0]  sel;
  logic        thru;
  logic [15:0] ram_a;
  logic [13:0] rom_a;
  logic [4:0]  io_a;
  logic [6:0]  boot_a;
  logic        ctl_we;
  logic [4:0]  ctl_ofs;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  msmd_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .write_i(wr), .addr_i(addr),
    .map_all_ram_i(ty), .mem_64k_i(m64), .page_hi_i(p1),
    .sel_o(sel), .ram_we_thru_o(thru), .ram_addr_o(ram_a), .rom_addr_o(rom_a),
    .io_addr_o(io_a), .boot_addr_o(boot_a), .ctl_we_o(ctl_we), .ctl_ofs_o(ctl_ofs)
  );

  task automatic check(input bit cond, input string req, input int act, input int exp);
    if (!cond) begin
      fails++;
      $display("FAIL %s addr=%h wr=%0d ty=%0d m64=%0d p1=%0d actual=%h expected=%h",
               req, addr, wr, ty, m64, p1, act, exp);
    end
  endtask

  task automatic apply(input bit v, input bit w, input logic [15:0] a);
    int ia;
    int esel, eram, erom, eio, eboot, eofs;
    bit all_ram, ram, ethru, ectl;
    @(negedge clk);
    valid = v; wr = w; addr = a;
    #2;
    vectors++;
    ia = int'(a);
    all_ram = m64 && ty;
    esel = 0; eram = ia; erom = 0; eio = 0; eboot = 0; eofs = ia % 32;
    ram = w ? (ia < 32768) : (ia < (all_ram ? 65280 : 32768));
    if (ram) begin
      esel = 1;
      if (m64 && !ty && p1 && ia < 32768) eram = ia + 32768;
    end else if (ia < 49152 || ia >= 65504) begin
      esel = ((ia / 8192) % 2 == 1) ? 4 : 2;
      erom = ia % 8192;
    end else if (ia < 65280) begin
      esel = 8;
      erom = ia % 16384;
    end else if (ia < 65376) begin
      esel = 16 << ((ia - 65280) / 32);
      eio = ia % 32;
    end else begin
      esel = 128;
      eboot = ia - 65376;
    end
    ethru = w && all_ram && ia >= 32768 && ia < 65280;
    ectl  = w && ia >= 65472 && ia < 65504;
    if (!v) begin
      check(sel == 8'h00, "R1 sel", sel, 0);
      check(!thru, "R1 thru", thru, 0);
      check(!ctl_we, "R1 ctl", ctl_we, 0);
      return;
    end
    if (esel == 1)        check(sel == esel[7:0], "R3", sel, esel);
    else if (esel <= 4)   check(sel == esel[7:0], "R5", sel, esel);
    else if (esel == 8)   check(sel == esel[7:0], "R6", sel, esel);
    else if (esel <= 64)  check(sel == esel[7:0], "R7", sel, esel);
    else                  check(sel == esel[7:0], "R8", sel, esel);
    if (esel == 1 || ethru) check(int'(ram_a) == eram, "R4 ram_addr", ram_a, eram);
    if (esel >= 2 && esel <= 4) check(int'(rom_a) == erom, "R5 rom_addr", rom_a, erom);
    if (esel == 8) check(int'(rom_a) == erom, "R6 rom_addr", rom_a, erom);
    if (esel >= 16 && esel <= 64) check(int'(io_a) == eio, "R7 io_addr", io_a, eio);
    if (esel == 128) check(int'(boot_a) == eboot, "R8 boot_addr", boot_a, eboot);
    check(ctl_we == ectl, "R9 strobe", ctl_we, ectl);
    if (ectl) check(int'(ctl_ofs) == eofs, "R9 offset", ctl_ofs, eofs);
    check(thru == ethru, "R10 thru", thru, ethru);
    check($countones(sel) == 1, "R2 onehot", sel, esel);
  endtask

  initial begin
    // reset phase: idle bus must stay quiet (R1)
    apply(1'b0, 1'b1, 16'hFFC5);
    apply(1'b0, 1'b0, 16'h1234);
    @(negedge clk); rst_n = 1'b1;
    apply(1'b0, 1'b1, 16'hFFD0);
    apply(1'b0, 1'b1, 16'hA000);
    for (int cfg = 0; cfg < 8; cfg++) begin
      @(negedge clk);
      ty = cfg[0]; m64 = cfg[1]; p1 = cfg[2];
      for (int w = 0; w < 2; w++) begin
        for (int j = 0; j < 512; j++) begin
          logic [8:0] jj;
          jj = 9'(j);
          apply(1'b1, w[0], {jj[8:1], jj[0] ? 8'hFF : 8'h00});
        end
        for (int k = 0; k < 256; k++) begin
          apply(1'b1, w[0], {8'hFF, 8'(k)});
        end
      end
      apply(1'b0, 1'b1, 16'hFFC1);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule